// File: doc/BRIEF.md
# Trimmed One-Second Divider with Sub-Second Countdown

This block turns a fast reference tick into a one-second pulse and a 1/256-second countdown. The length of each second, counted in reference ticks, is set by two trim values: a coarse count and a 2-bit fine count. A second is made of four equal segments of `coarse` ticks each. The first `fine` segments each get one extra tick, so the remainder is spread across the second and is not bunched at its end. At a 262144 Hz reference the nominal pair (coarse 0x10000, fine 0) gives exactly one second. Raising the total count slows the time base. For example, coarse 0x10040 with fine 3 gives 262403 ticks, about -988 ppm.

Software writes new trim values through a small register port. The values wait in shadow registers and only take effect when the current second ends, so a write never changes the length of the second already in progress. A readable countdown shows how many nominal 1/256-second periods are left before the next second boundary. A restart strobe begins a fresh second at once, with the countdown back at its top value. Each segment is split into 64 steps of `coarse >> 6` ticks, and the last step of a segment also absorbs any leftover ticks. This keeps every segment boundary lined up with a multiple of 64 in the countdown.

Top module: `rtc_trim_divider`

## Requirements
- R1: While `ref_en` is high every cycle, successive `sec_pulse` assertions are exactly 4*coarse + fine cycles apart, for coarse of at least 128.
- R2: After reset the trim is coarse 0x10000 and fine 0, `subsec` reads 255 and `sec_pulse` is low, so the first countdown decrement comes 1024 ticks after reset is released.
- R3: Segments 0 to fine-1 are each one tick longer than coarse. With coarse 256 and fine 3, `subsec` still reads 192 256 ticks after a restart and reads 191 one tick later.
- R4: `subsec` counts down by one every coarse>>6 ticks inside a segment and by one at each segment end, starting from 255. It always equals the number of 1/256-second periods still to run.
- R5: `sec_pulse` is high for exactly one cycle, namely the cycle in which `subsec` has wrapped from 0 back to 255.
- R6: Trim writes only change the pending values. The second in progress keeps its old length, and the new length applies from the next boundary (or restart).
- R7: A one-cycle `subsec_rst` starts a new full second. In the following cycle `subsec` is 255 and `sec_pulse` stays low, even if a boundary was due on that same tick, and the next pulse comes 4*coarse + fine ticks later.
- R8: While `ref_en` is low, `subsec` holds its value and no pulse is issued, so the second is stretched by the number of cycles without a tick.
- R9: `wr_sel` = 0 writes `wr_data` to the coarse value. `wr_sel` = 1 writes the low 2 bits of `wr_data` to the fine value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference tick qualifier; one count per high cycle |
| wr_en | input | 1 | Trim write strobe |
| wr_sel | input | 1 | Trim write target: 0 coarse, 1 fine |
| wr_data | input | 20 | Trim write value |
| subsec_rst | input | 1 | Restart strobe for the countdown and the second |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |
| subsec | output | 8 | Remaining 1/256-second periods before the next boundary |

## Verification
The assertions assume that the coarse value put into use is at least 128. Below that, a step of coarse>>6 ticks could be zero and a segment could not hold its 64 steps. They also assume that a second lasts long enough that two boundaries never fall on adjacent cycles. The stimulus writes only coarse values of 128 and above before any restart or boundary, and it drives the restart strobe for one cycle at a time. The tick-gating and restart tests place the strobes mid-second and also exactly on a boundary tick, so that the priority of the restart over the wrap is exercised.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int unsigned RT_COARSE_W   = 20;
  localparam int unsigned RT_FINE_W     = 2;
  localparam int unsigned RT_SUB_W      = 8;
  localparam int unsigned RT_RST_COARSE = 32'h10000;
  localparam int unsigned RT_MIN_COARSE = 128;

  typedef enum logic {
    SEL_COARSE = 1'b0,
    SEL_FINE   = 1'b1
  } trim_sel_e;
endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
  import rtc_trim_pkg::*;
#(
  parameter int unsigned CW        = RT_COARSE_W,
  parameter int unsigned FW        = RT_FINE_W,
  parameter int unsigned RST_COARSE = RT_RST_COARSE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          commit,
  output logic [CW-1:0] pend_c,
  output logic [FW-1:0] pend_f,
  output logic [CW-1:0] act_c,
  output logic [FW-1:0] act_f
);
  localparam logic [CW-1:0] RST_C = CW'(RST_COARSE);

  trim_sel_e sel;
  assign sel = trim_sel_e'(wr_sel);

  // pending (shadow) values, written by the port
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_c <= RST_C;
      pend_f <= '0;
    end else if (wr_en) begin
      if (sel == SEL_COARSE) pend_c <= wr_data;
      else                   pend_f <= wr_data[FW-1:0];
    end
  end

  // values in use, moved over only at a second boundary or restart
  always_ff @(posedge clk) begin
    if (rst) begin
      act_c <= RST_C;
      act_f <= '0;
    end else if (commit) begin
      act_c <= pend_c;
      act_f <= pend_f;
    end
  end

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_c) && $stable(act_f)));

  assert_coarse_min_R1: assert property (@(posedge clk) disable iff (rst)
    act_c >= CW'(RT_MIN_COARSE));
endmodule

// File: rtl/rtc_seg_seq.sv
module rtc_seg_seq
  import rtc_trim_pkg::*;
#(
  parameter int unsigned CW         = RT_COARSE_W,
  parameter int unsigned FW         = RT_FINE_W,
  parameter int unsigned RST_COARSE = RT_RST_COARSE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] act_c,
  input  logic [FW-1:0] act_f,
  input  logic [CW-1:0] pend_c,
  input  logic [FW-1:0] pend_f,
  output logic          seg_end,
  output logic          sec_end
);
  localparam logic [FW-1:0] LAST  = '1;
  localparam logic [CW:0]   ONE   = (CW+1)'(1);
  localparam logic [CW:0]   RST_Q = (CW+1)'(RST_COARSE - 1);

  logic [FW-1:0] seg_idx;
  logic [CW:0]   seg_cnt;

  // length of segment k: coarse, plus one while k is below fine
  function automatic logic [CW:0] seg_len(input logic [CW-1:0] c,
                                          input logic [FW-1:0] f,
                                          input logic [FW-1:0] k);
    seg_len = {1'b0, c} + {{CW{1'b0}}, (k < f)};
  endfunction

  assign seg_end = tick && (seg_cnt == '0);
  assign sec_end = seg_end && (seg_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_idx <= '0;
      seg_cnt <= RST_Q;
    end else if (restart) begin
      seg_idx <= '0;
      seg_cnt <= seg_len(pend_c, pend_f, '0) - ONE;
    end else if (tick) begin
      if (seg_cnt == '0) begin
        if (seg_idx == LAST) begin
          seg_idx <= '0;
          seg_cnt <= seg_len(pend_c, pend_f, '0) - ONE;
        end else begin
          seg_idx <= seg_idx + 1'b1;
          seg_cnt <= seg_len(act_c, act_f, seg_idx + 1'b1) - ONE;
        end
      end else begin
        seg_cnt <= seg_cnt - ONE;
      end
    end
  end

  assert_seg_bound_R1: assert property (@(posedge clk) disable iff (rst)
    seg_cnt <= {1'b0, act_c});
endmodule

// File: rtl/rtc_subsec_cnt.sv
module rtc_subsec_cnt
  import rtc_trim_pkg::*;
#(
  parameter int unsigned CW         = RT_COARSE_W,
  parameter int unsigned FW         = RT_FINE_W,
  parameter int unsigned SW         = RT_SUB_W,
  parameter int unsigned RST_COARSE = RT_RST_COARSE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic          seg_end,
  input  logic          sec_end,
  input  logic [CW-1:0] act_c,
  input  logic [CW-1:0] pend_c,
  output logic [SW-1:0] subsec,
  output logic          pulse
);
  localparam int unsigned SEG_STEPS = (1 << SW) >> FW;
  localparam int unsigned SH        = $clog2(SEG_STEPS);
  localparam int unsigned SCW       = CW - SH;
  localparam logic [SCW-1:0] S_ONE  = SCW'(1);
  localparam logic [SCW-1:0] RST_S  = SCW'((RST_COARSE >> SH) - 1);

  logic [SCW-1:0] step_cnt;
  logic [SW-1:0]  sub_q;
  logic [SCW-1:0] act_step;
  logic [SCW-1:0] pend_step;

  assign act_step  = act_c[CW-1:SH];
  assign pend_step = pend_c[CW-1:SH];

  always_ff @(posedge clk) begin
    if (rst) begin
      step_cnt <= RST_S;
      sub_q    <= '1;
      pulse    <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (restart) begin
        step_cnt <= pend_step - S_ONE;
        sub_q    <= '1;
      end else if (tick) begin
        if (seg_end) begin
          sub_q    <= sub_q - 1'b1;
          pulse    <= (sub_q == '0);
          step_cnt <= (sec_end ? pend_step : act_step) - S_ONE;
        end else if (step_cnt == '0) begin
          step_cnt <= act_step - S_ONE;
          if (sub_q[SH-1:0] != '0) sub_q <= sub_q - 1'b1;
        end else begin
          step_cnt <= step_cnt - S_ONE;
        end
      end
    end
  end

  assign subsec = sub_q;

  assert_step_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    act_step != '0);

  assert_seg_align_R3: assert property (@(posedge clk) disable iff (rst)
    (seg_end && !restart) |-> (sub_q[SH-1:0] == '0));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(sub_q));
endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtc_trim_pkg::*;
#(
  parameter int unsigned CW         = RT_COARSE_W,
  parameter int unsigned FW         = RT_FINE_W,
  parameter int unsigned SW         = RT_SUB_W,
  parameter int unsigned RST_COARSE = RT_RST_COARSE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          subsec_rst,
  output logic          sec_pulse,
  output logic [SW-1:0] subsec
);
  logic [CW-1:0] pend_c, act_c;
  logic [FW-1:0] pend_f, act_f;
  logic          seg_end, sec_end, commit;

  assign commit = subsec_rst || sec_end;

  rtc_trim_regs #(.CW(CW), .FW(FW), .RST_COARSE(RST_COARSE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .commit(commit), .pend_c(pend_c), .pend_f(pend_f),
    .act_c(act_c), .act_f(act_f)
  );

  rtc_seg_seq #(.CW(CW), .FW(FW), .RST_COARSE(RST_COARSE)) u_seq (
    .clk(clk), .rst(rst), .tick(ref_en), .restart(subsec_rst),
    .act_c(act_c), .act_f(act_f), .pend_c(pend_c), .pend_f(pend_f),
    .seg_end(seg_end), .sec_end(sec_end)
  );

  rtc_subsec_cnt #(.CW(CW), .FW(FW), .SW(SW), .RST_COARSE(RST_COARSE)) u_sub (
    .clk(clk), .rst(rst), .tick(ref_en), .restart(subsec_rst),
    .seg_end(seg_end), .sec_end(sec_end), .act_c(act_c), .pend_c(pend_c),
    .subsec(subsec), .pulse(sec_pulse)
  );

  assert_pulse_top_R5: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> (subsec == '1));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> !sec_pulse);

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    subsec_rst |=> ((subsec == '1) && !sec_pulse));
endmodule

// File: tb/sim_rtc_trim_divider.sv
module sim_rtc_trim_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_en = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [19:0] wr_data = '0;
  logic        subsec_rst = 1'b0;
  logic        sec_pulse;
  logic [7:0]  subsec;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rtc_trim_divider u0 (
    .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .subsec_rst(subsec_rst), .sec_pulse(sec_pulse),
    .subsec(subsec)
  );

  // coarse, fine, expected ticks per second (R1)
  localparam int unsigned TBL [5][3] = '{
    '{256, 0, 1024}, '{256, 3, 1027}, '{300, 1, 1201},
    '{512, 2, 2050}, '{128, 3, 515}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [19:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic restart();
    subsec_rst = 1'b1;
    @(negedge clk);
    subsec_rst = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sec_pulse && n < 6000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R2 reset subsec", subsec, 255);
    chk("R2 reset pulse", sec_pulse, 0);
    rst = 1'b0;
    // R2: default coarse 0x10000 -> step of 1024 ticks
    repeat (1023) @(negedge clk);
    chk("R2 default step not yet", subsec, 255);
    @(negedge clk);
    chk("R2 default first step", subsec, 254);

    // R1 / R9: table of trim pairs and period lengths
    for (int i = 0; i < 5; i++) begin
      wr(1'b0, 20'(TBL[i][0]));
      wr(1'b1, 20'(TBL[i][1]));
      restart();
      wait_pulse(n);
      chk($sformatf("R1 vec%0d first period", i), n, TBL[i][2]);
      wait_pulse(n);
      chk($sformatf("R1 R9 vec%0d second period", i), n, TBL[i][2]);
    end

    // R3 / R4: fine spread and step countdown
    wr(1'b0, 20'd256);
    wr(1'b1, 20'd3);
    restart();
    repeat (3) @(negedge clk);
    chk("R4 before first step", subsec, 255);
    @(negedge clk);
    chk("R4 first step", subsec, 254);
    repeat (252) @(negedge clk);
    chk("R3 extra tick holds 192", subsec, 192);
    @(negedge clk);
    chk("R3 segment end 191", subsec, 191);

    // R5: pulse shape
    wr(1'b1, 20'd0);
    restart();
    wait_pulse(n);
    chk("R5 period", n, 1024);
    chk("R5 subsec at pulse", subsec, 255);

    // R6 / R9: writes are held until the boundary
    wr(1'b0, 20'd300);
    chk("R5 pulse one cycle", sec_pulse, 0);
    wr(1'b1, 20'd5);
    wait_pulse(n);
    chk("R6 current second unchanged", n, 1022);
    wait_pulse(n);
    chk("R6 R9 new length 1201", n, 1201);

    // R7: restart mid-second and on a boundary tick
    wr(1'b0, 20'd256);
    wr(1'b1, 20'd0);
    wait_pulse(n);
    wait_pulse(n);
    chk("R7 setup period", n, 1024);
    repeat (100) @(negedge clk);
    restart();
    chk("R7 mid restart subsec", subsec, 255);
    chk("R7 mid restart pulse", sec_pulse, 0);
    wait_pulse(n);
    chk("R7 full second after restart", n, 1024);
    repeat (1023) @(negedge clk);
    restart();
    chk("R7 boundary restart no pulse", sec_pulse, 0);
    chk("R7 boundary restart subsec", subsec, 255);
    wait_pulse(n);
    chk("R7 second after boundary restart", n, 1024);

    // R8: gated reference
    ref_en = 1'b0;
    repeat (50) @(negedge clk);
    chk("R8 held at top", subsec, 255);
    chk("R8 no pulse while gated", sec_pulse, 0);
    ref_en = 1'b1;
    repeat (100) @(negedge clk);
    chk("R8 running", subsec, 230);
    ref_en = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 frozen mid-second", subsec, 230);
    ref_en = 1'b1;
    wait_pulse(n);
    chk("R8 stretched remainder", n, 924);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule